// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Controller

This block runs bus cycles for a 16-bit processor whose external bus carries the address and the data on the same lines at different times. The core asks for one cycle at a time. A request names the cycle kind, a 20-bit address, a byte-or-word size, the write data and a flag that lets the cycle finish without waiting for the ready input. The controller then moves through its phases. It drives a 3-bit status code, an address latch strobe, a byte-high enable, read and write strobes, a transceiver enable and the four upper address lines. It also drives and samples the shared address/data lines.

The sequencer has five states. IDLE means no cycle is running. T1 is the address phase. T2 is the first strobe phase. T3 is the strobe phase in which ready is sampled; it repeats as a wait state while ready is low. T4 releases the strobes. The transitions are:
- IDLE→T1 when an aligned request is accepted, otherwise IDLE→IDLE.
- T1→T2 and T2→T3 always.
- T3→T4 when ready is high or the cycle ignores ready, otherwise T3→T3.
- T4→T1 when a new request is accepted, otherwise T4→IDLE.

A cycle with no wait states takes four clocks, and a new request can be taken during T4 so that cycles run back to back.

Top module: `mux_bus_ctrl`

## Requirements
- R1: After reset the outputs are in the idle state: `bus_status`=111, `ale`=0, `rd_n`=`wr_n`=`den_n`=`bhe_n`=1, `a_hi`=0, `ad_oe`=0, `done`=0, and `req_ready`=1.
- R2: The request kind code sets the status code while the cycle is in T1, T2 and T3.
  - Codes 0 to 6 (interrupt acknowledge, I/O read, I/O write, halt, fetch, memory read, memory write) give the status equal to the code.
  - Code 7 (refresh) gives status 101.
  - In T4 and IDLE the status is 111.
- R3: A request taken at a clock edge puts the bus into T1 in the next cycle. In T1 `ale`=1, `a_hi`=address bits 19..16, `ad_out` bits 15..1 = address bits 15..1 and `ad_oe`=1. `ale` is high for exactly one cycle. With ready high the cycle is T1, T2, T3, T4, and `done`=1 only in T4.
- R4: `a_hi` is 0 in every state other than T1.
- R5: {`bhe_n`, A0} (A0 = `ad_out` bit 0 in T1) is 00 for a word, 01 for a byte at an odd address, 10 for a byte at an even address and 11 for refresh. `bhe_n` keeps this value through T1, T2 and T3.
- R6: Each T3 in which `rdy` is sampled low adds one more T3 wait cycle. The strobes stay asserted during wait cycles.
- R7: If `req_ign_rdy` was set with the request, T3 lasts one cycle whatever `rdy` is.
- R8: The strobes are asserted during T2 and T3 only.
  - `rd_n` is 0 for interrupt acknowledge, I/O read, fetch and memory read.
  - `wr_n` is 0 for I/O write and memory write, and `ad_out`=write data with `ad_oe`=1.
  - In read cycles `ad_oe`=0 during T2 and T3.
- R9: `den_n` is 0 only in T2 and T3 of cycles that move data (reads and writes), and never while `ale`=1.
- R10: Halt and refresh cycles keep `rd_n`, `wr_n` and `den_n` high and `ad_oe` low throughout.
- R11: For read kinds, `rdata` holds the value of `ad_in` at the end of the last T3. It is valid while `done`=1.
- R12: A word request at an odd address is never accepted. The bus stays idle and `done` stays 0 while it is presented.
- R13: `req_ready`=1 in IDLE and T4. A request taken in T4 starts the next T1 directly, with no IDLE cycle in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Core presents a request |
| req_kind | input | 3 | Cycle kind code (see R2) |
| req_addr | input | 20 | Byte address |
| req_word | input | 1 | 1 = word transfer, 0 = byte |
| req_wdata | input | 16 | Write data |
| req_ign_rdy | input | 1 | Finish this cycle without waiting for ready |
| req_ready | output | 1 | Controller can take an aligned request |
| done | output | 1 | Cycle in its final state (T4) |
| rdata | output | 16 | Captured read data |
| bus_status | output | 3 | Cycle status code |
| ale | output | 1 | Address latch strobe |
| bhe_n | output | 1 | Byte-high enable, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| den_n | output | 1 | Transceiver enable, active low |
| a_hi | output | 4 | Upper address lines |
| ad_out | output | 16 | Shared bus output value |
| ad_oe | output | 1 | Shared bus output enable |
| ad_in | input | 16 | Shared bus input value |
| rdy | input | 1 | Ready from the target |

## Verification
The assertions assume three things about the inputs:
- `req_kind` is a defined code.
- `rdy` and `ad_in` are stable around the rising edge.
- The core does not change a request while it waits to be accepted.

The directed stimulus changes every input only at the falling edge. It drops `req_valid` in the cycle after acceptance, and sets `rdy` for each T3 visit before the edge that samples it. Ready-ignored cycles are run with `rdy` held low, so an early exit can only come from the ignore flag.

// File: rtl/mbc_pkg.sv
package mbc_pkg;

    typedef enum logic [2:0] {
        CK_INTA  = 3'd0,
        CK_IORD  = 3'd1,
        CK_IOWR  = 3'd2,
        CK_HALT  = 3'd3,
        CK_FETCH = 3'd4,
        CK_MRD   = 3'd5,
        CK_MWR   = 3'd6,
        CK_RFSH  = 3'd7
    } cyc_kind_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_T1,
        PH_T2,
        PH_T3,
        PH_T4
    } phase_e;

    localparam logic [2:0] STATUS_PASSIVE = 3'b111;

    typedef struct packed {
        logic [2:0] code;
        logic       rd;
        logic       wr;
        logic       rfsh;
    } cyc_attr_t;

endpackage

// File: rtl/mbc_cycle_decode.sv
module mbc_cycle_decode
    import mbc_pkg::*;
(
    input  cyc_kind_e kind,
    output cyc_attr_t attr
);

    always_comb begin
        attr = '{code: STATUS_PASSIVE, rd: 1'b0, wr: 1'b0, rfsh: 1'b0};
        unique case (kind)
            CK_INTA:  attr = '{code: 3'b000, rd: 1'b1, wr: 1'b0, rfsh: 1'b0};
            CK_IORD:  attr = '{code: 3'b001, rd: 1'b1, wr: 1'b0, rfsh: 1'b0};
            CK_IOWR:  attr = '{code: 3'b010, rd: 1'b0, wr: 1'b1, rfsh: 1'b0};
            CK_HALT:  attr = '{code: 3'b011, rd: 1'b0, wr: 1'b0, rfsh: 1'b0};
            CK_FETCH: attr = '{code: 3'b100, rd: 1'b1, wr: 1'b0, rfsh: 1'b0};
            CK_MRD:   attr = '{code: 3'b101, rd: 1'b1, wr: 1'b0, rfsh: 1'b0};
            CK_MWR:   attr = '{code: 3'b110, rd: 1'b0, wr: 1'b1, rfsh: 1'b0};
            CK_RFSH:  attr = '{code: 3'b101, rd: 1'b0, wr: 1'b0, rfsh: 1'b1};
        endcase
    end

endmodule

// File: rtl/mbc_seq.sv
module mbc_seq
    import mbc_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_word,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_ign_rdy,
    input  logic              rdy,
    input  logic [DATA_W-1:0] ad_in,
    input  logic              hold_is_rd,
    output phase_e            phase,
    output cyc_kind_e         hold_kind,
    output logic [ADDR_W-1:0] hold_addr,
    output logic              hold_word,
    output logic [DATA_W-1:0] hold_wdata,
    output logic              req_ready,
    output logic              done,
    output logic [DATA_W-1:0] rdata
);

    phase_e phase_nx;
    logic   hold_ign;
    logic   misaligned;
    logic   accept;
    logic   t3_exit;

    assign req_ready  = (phase == PH_IDLE) || (phase == PH_T4);
    assign misaligned = req_word && req_addr[0];
    assign accept     = req_valid && req_ready && !misaligned;
    assign t3_exit    = (phase == PH_T3) && (rdy || hold_ign);
    assign done       = (phase == PH_T4);

    always_comb begin
        phase_nx = phase;
        unique case (phase)
            PH_IDLE: phase_nx = accept ? PH_T1 : PH_IDLE;
            PH_T1:   phase_nx = PH_T2;
            PH_T2:   phase_nx = PH_T3;
            PH_T3:   phase_nx = t3_exit ? PH_T4 : PH_T3;
            PH_T4:   phase_nx = accept ? PH_T1 : PH_IDLE;
            default: phase_nx = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
        end else begin
            phase <= phase_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_kind  <= CK_HALT;
            hold_addr  <= '0;
            hold_word  <= 1'b0;
            hold_wdata <= '0;
            hold_ign   <= 1'b0;
        end else if (accept) begin
            hold_kind  <= cyc_kind_e'(req_kind);
            hold_addr  <= req_addr;
            hold_word  <= req_word;
            hold_wdata <= req_wdata;
            hold_ign   <= req_ign_rdy;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (t3_exit && hold_is_rd) begin
            rdata <= ad_in;
        end
    end

    assert_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_T3 && !rdy && !hold_ign) |=> (phase == PH_T3));

    assert_ignore_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_T3 && hold_ign) |=> (phase == PH_T4));

    assert_t1_t2_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_T1) |=> (phase == PH_T2));

    assert_t2_t3_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_T2) |=> (phase == PH_T3));

    assert_misalign_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE && req_valid && req_word && req_addr[0]) |=> (phase == PH_IDLE));

endmodule

// File: rtl/mbc_pin_mux.sv
module mbc_pin_mux
    import mbc_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  phase_e                   phase,
    input  cyc_attr_t                attr,
    input  logic [ADDR_W-1:0]        hold_addr,
    input  logic                     hold_word,
    input  logic [DATA_W-1:0]        hold_wdata,
    output logic [2:0]               bus_status,
    output logic                     ale,
    output logic                     bhe_n,
    output logic                     rd_n,
    output logic                     wr_n,
    output logic                     den_n,
    output logic [ADDR_W-DATA_W-1:0] a_hi,
    output logic [DATA_W-1:0]        ad_out,
    output logic                     ad_oe
);

    localparam int HI_W = ADDR_W - DATA_W;

    logic in_addr;
    logic in_data;
    logic active;
    logic lane_bhe_n;
    logic lane_a0;

    assign in_addr = (phase == PH_T1);
    assign in_data = (phase == PH_T2) || (phase == PH_T3);
    assign active  = in_addr || in_data;

    always_comb begin
        if (attr.rfsh) begin
            lane_bhe_n = 1'b1;
            lane_a0    = 1'b1;
        end else if (hold_word) begin
            lane_bhe_n = 1'b0;
            lane_a0    = hold_addr[0];
        end else begin
            lane_bhe_n = !hold_addr[0];
            lane_a0    = hold_addr[0];
        end
    end

    always_comb begin
        bus_status = active ? attr.code : STATUS_PASSIVE;
        ale        = in_addr;
        bhe_n      = active ? lane_bhe_n : 1'b1;
        a_hi       = in_addr ? hold_addr[ADDR_W-1:DATA_W] : {HI_W{1'b0}};
        rd_n       = !(in_data && attr.rd);
        wr_n       = !(in_data && attr.wr);
        den_n      = !(in_data && (attr.rd || attr.wr));
        ad_oe      = in_addr || (in_data && attr.wr);
        if (in_addr) begin
            ad_out = {hold_addr[DATA_W-1:1], lane_a0};
        end else if (in_data && attr.wr) begin
            ad_out = hold_wdata;
        end else begin
            ad_out = '0;
        end
    end

    assert_ale_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);

    assert_den_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> den_n);

    assert_ahi_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ale |-> (a_hi == '0));

    assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_n || wr_n);

endmodule

// File: rtl/mux_bus_ctrl.sv
module mux_bus_ctrl
    import mbc_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [2:0]               req_kind,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic                     req_word,
    input  logic [DATA_W-1:0]        req_wdata,
    input  logic                     req_ign_rdy,
    output logic                     req_ready,
    output logic                     done,
    output logic [DATA_W-1:0]        rdata,
    output logic [2:0]               bus_status,
    output logic                     ale,
    output logic                     bhe_n,
    output logic                     rd_n,
    output logic                     wr_n,
    output logic                     den_n,
    output logic [ADDR_W-DATA_W-1:0] a_hi,
    output logic [DATA_W-1:0]        ad_out,
    output logic                     ad_oe,
    input  logic [DATA_W-1:0]        ad_in,
    input  logic                     rdy
);

    phase_e            phase;
    cyc_kind_e         hold_kind;
    cyc_attr_t         attr;
    logic [ADDR_W-1:0] hold_addr;
    logic              hold_word;
    logic [DATA_W-1:0] hold_wdata;

    mbc_cycle_decode u_decode (
        .kind (hold_kind),
        .attr (attr)
    );

    mbc_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_kind    (req_kind),
        .req_addr    (req_addr),
        .req_word    (req_word),
        .req_wdata   (req_wdata),
        .req_ign_rdy (req_ign_rdy),
        .rdy         (rdy),
        .ad_in       (ad_in),
        .hold_is_rd  (attr.rd),
        .phase       (phase),
        .hold_kind   (hold_kind),
        .hold_addr   (hold_addr),
        .hold_word   (hold_word),
        .hold_wdata  (hold_wdata),
        .req_ready   (req_ready),
        .done        (done),
        .rdata       (rdata)
    );

    mbc_pin_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase      (phase),
        .attr       (attr),
        .hold_addr  (hold_addr),
        .hold_word  (hold_word),
        .hold_wdata (hold_wdata),
        .bus_status (bus_status),
        .ale        (ale),
        .bhe_n      (bhe_n),
        .rd_n       (rd_n),
        .wr_n       (wr_n),
        .den_n      (den_n),
        .a_hi       (a_hi),
        .ad_out     (ad_out),
        .ad_oe      (ad_oe)
    );

    assert_halt_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_status == 3'b011) |-> (rd_n && wr_n && den_n && !(ad_oe && !ale)));

    assert_passive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_status == STATUS_PASSIVE) |-> (rd_n && wr_n && den_n && !ale));

    assert_done_passive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (bus_status == STATUS_PASSIVE));

endmodule

// File: tb/mux_bus_ctrl_tb_top.sv
module mux_bus_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_kind = 3'd0;
    logic [19:0] req_addr = '0;
    logic        req_word = 1'b0;
    logic [15:0] req_wdata = '0;
    logic        req_ign_rdy = 1'b0;
    logic        req_ready, done;
    logic [15:0] rdata;
    logic [2:0]  bus_status;
    logic        ale, bhe_n, rd_n, wr_n, den_n, ad_oe;
    logic [3:0]  a_hi;
    logic [15:0] ad_out;
    logic [15:0] ad_in = '0;
    logic        rdy = 1'b1;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [2:0]  nx_kind;
    logic [19:0] nx_addr;
    logic        nx_word;
    logic [15:0] nx_wdata;

    always #4 clk = ~clk;

    mux_bus_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_word(req_word), .req_wdata(req_wdata),
        .req_ign_rdy(req_ign_rdy), .req_ready(req_ready), .done(done),
        .rdata(rdata), .bus_status(bus_status), .ale(ale), .bhe_n(bhe_n),
        .rd_n(rd_n), .wr_n(wr_n), .den_n(den_n), .a_hi(a_hi),
        .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .rdy(rdy)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [2:0] exp_status(input logic [2:0] k);
        return (k == 3'd7) ? 3'b101 : k;
    endfunction

    function automatic bit kind_rd(input logic [2:0] k);
        return (k == 3'd0) || (k == 3'd1) || (k == 3'd4) || (k == 3'd5);
    endfunction

    function automatic bit kind_wr(input logic [2:0] k);
        return (k == 3'd2) || (k == 3'd6);
    endfunction

    function automatic logic [1:0] exp_lane(input logic [2:0] k, input bit w, input bit a0);
        if (k == 3'd7) return 2'b11;
        if (w) return 2'b00;
        return a0 ? 2'b01 : 2'b10;
    endfunction

    task automatic idle_check(input string tag);
        chk({tag, " status"}, 32'(bus_status), 32'(3'b111));
        chk({tag, " ale"}, 32'(ale), 32'd0);
        chk({tag, " strobes"}, 32'({rd_n, wr_n, den_n}), 32'(3'b111));
        chk({tag, " a_hi"}, 32'(a_hi), 32'd0);
    endtask

    // Runs one cycle and checks every state. issued=1: request already taken, now in T1.
    task automatic run_cycle(input logic [2:0] k, input logic [19:0] addr, input bit w,
                             input logic [15:0] wd, input int waits, input bit ign,
                             input logic [15:0] rdval, input bit issued, input bit chain);
        logic [1:0] lane;
        bit rdk, wrk, xfer;
        lane = exp_lane(k, w, addr[0]);
        rdk = kind_rd(k);
        wrk = kind_wr(k);
        xfer = rdk || wrk;
        if (!issued) begin
            @(negedge clk);
            req_valid = 1'b1; req_kind = k; req_addr = addr; req_word = w;
            req_wdata = wd; req_ign_rdy = ign;
            chk("R13 ready before accept", 32'(req_ready), 32'd1);
            @(negedge clk);
        end
        req_valid = 1'b0;
        // T1
        chk("R3 T1 ale", 32'(ale), 32'd1);
        chk("R2 T1 status", 32'(bus_status), 32'(exp_status(k)));
        chk("R3 T1 a_hi", 32'(a_hi), 32'(addr[19:16]));
        chk("R3 T1 ad_out", 32'(ad_out[15:1]), 32'(addr[15:1]));
        chk("R3 T1 ad_oe", 32'(ad_oe), 32'd1);
        chk("R5 T1 lane", 32'({bhe_n, ad_out[0]}), 32'(lane));
        chk("R9 T1 den_n", 32'(den_n), 32'd1);
        chk("R8 T1 strobes", 32'({rd_n, wr_n}), 32'(2'b11));
        chk("R3 T1 done", 32'(done), 32'd0);
        @(negedge clk);
        // T2
        chk("R3 T2 ale", 32'(ale), 32'd0);
        chk("R2 T2 status", 32'(bus_status), 32'(exp_status(k)));
        chk("R4 T2 a_hi", 32'(a_hi), 32'd0);
        chk("R5 T2 bhe_n", 32'(bhe_n), 32'(lane[1]));
        chk("R8 T2 rd_n", 32'(rd_n), 32'(!rdk));
        chk("R8 T2 wr_n", 32'(wr_n), 32'(!wrk));
        chk("R9 T2 den_n", 32'(den_n), 32'(!xfer));
        chk("R10 T2 ad_oe", 32'(ad_oe), 32'(wrk));
        if (wrk) chk("R8 T2 wdata", 32'(ad_out), 32'(wd));
        @(negedge clk);
        // T3 and waits
        for (int i = 0; i <= waits; i++) begin
            rdy = ign ? 1'b0 : (i == waits);
            ad_in = (i == waits) ? rdval : ~rdval;
            chk("R6 T3 status", 32'(bus_status), 32'(exp_status(k)));
            chk("R6 T3 rd_n", 32'(rd_n), 32'(!rdk));
            chk("R6 T3 wr_n", 32'(wr_n), 32'(!wrk));
            chk("R9 T3 den_n", 32'(den_n), 32'(!xfer));
            chk("R4 T3 a_hi", 32'(a_hi), 32'd0);
            chk("R6 T3 done", 32'(done), 32'd0);
            if (wrk) chk("R8 T3 wdata", 32'(ad_out), 32'(wd));
            @(negedge clk);
        end
        rdy = 1'b1;
        // T4
        chk("R3 T4 done", 32'(done), 32'd1);
        idle_check("R2 T4");
        if (rdk) chk("R11 rdata", 32'(rdata), 32'(rdval));
        if (chain) begin
            req_valid = 1'b1; req_kind = nx_kind; req_addr = nx_addr; req_word = nx_word;
            req_wdata = nx_wdata; req_ign_rdy = 1'b0;
            chk("R13 ready in T4", 32'(req_ready), 32'd1);
            @(negedge clk);
        end else begin
            @(negedge clk);
            chk("R3 idle done", 32'(done), 32'd0);
            idle_check("R13 idle after T4");
        end
    endtask

    task automatic t_reset();
        idle_check("R1 reset");
        chk("R1 reset bhe_n", 32'(bhe_n), 32'd1);
        chk("R1 reset ad_oe", 32'(ad_oe), 32'd0);
        chk("R1 reset done", 32'(done), 32'd0);
        chk("R1 reset req_ready", 32'(req_ready), 32'd1);
    endtask

    task automatic t_reads();
        run_cycle(3'd5, 20'hA1234, 1'b1, 16'h0, 0, 1'b0, 16'hBEEF, 1'b0, 1'b0); // R11 word
        run_cycle(3'd1, 20'h30056, 1'b0, 16'h0, 3, 1'b0, 16'h5AA5, 1'b0, 1'b0); // R6 even byte
        run_cycle(3'd4, 20'hF0101, 1'b0, 16'h0, 1, 1'b0, 16'h1357, 1'b0, 1'b0); // R5 odd byte
        run_cycle(3'd0, 20'h00000, 1'b1, 16'h0, 0, 1'b0, 16'h00C3, 1'b0, 1'b0); // R2 inta
    endtask

    task automatic t_writes();
        run_cycle(3'd6, 20'h7FFF3, 1'b0, 16'hC0DE, 2, 1'b0, 16'h0, 1'b0, 1'b0); // R8 odd byte
        run_cycle(3'd2, 20'h00F80, 1'b1, 16'h8421, 0, 1'b1, 16'h0, 1'b0, 1'b0); // R7 ignore
    endtask

    task automatic t_ignore_read();
        run_cycle(3'd5, 20'h12340, 1'b1, 16'h0, 0, 1'b1, 16'h7E7E, 1'b0, 1'b0); // R7 R11
    endtask

    task automatic t_quiet();
        run_cycle(3'd3, 20'h00000, 1'b0, 16'h0, 1, 1'b0, 16'h0, 1'b0, 1'b0); // R10 halt
        run_cycle(3'd7, 20'h4A5A4, 1'b0, 16'h0, 0, 1'b0, 16'h0, 1'b0, 1'b0); // R10 refresh
    endtask

    task automatic t_misaligned();
        @(negedge clk);
        req_valid = 1'b1; req_kind = 3'd5; req_addr = 20'h10001; req_word = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R12 misaligned ale", 32'(ale), 32'd0);
            chk("R12 misaligned status", 32'(bus_status), 32'(3'b111));
            chk("R12 misaligned done", 32'(done), 32'd0);
        end
        req_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_back_to_back();
        nx_kind = 3'd6; nx_addr = 20'h9ABC0; nx_word = 1'b1; nx_wdata = 16'hFACE;
        run_cycle(3'd5, 20'h22222, 1'b1, 16'h0, 0, 1'b0, 16'h4321, 1'b0, 1'b1); // R13
        run_cycle(nx_kind, nx_addr, nx_word, nx_wdata, 1, 1'b0, 16'h0, 1'b1, 1'b0); // R13
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_reads();
        t_writes();
        t_ignore_read();
        t_quiet();
        t_misaligned();
        t_back_to_back();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog R3: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule